// File: doc/BRIEF.md
# Always-On Interrupt Aggregator with Programmable NMI Trigger

This block collects sixteen interrupt sources into one latched pending word and presents two outputs. Source 0 is an external non-maskable interrupt pin. It passes through a two-flop synchronizer, and its trigger type can be set to level low, falling edge, level high or rising edge. Sources 1 to 15 are synchronous active-high levels. A pending bit sets whenever its source reports a hit, whatever its enable or mask bits hold. Software clears pending bits by writing ones to them.

Each pending bit is gated by its enable bit (1 enables) and its mask bit (1 masks). The OR of all gated bits drives a global request line to a coprocessor. Gated bit 0 alone drives a dedicated active-high level line to the main interrupt controller. A vector register returns a programmable base address plus four times the number of the lowest-numbered gated source. The register bus is a simple single-cycle 32-bit port with writes and combinational reads.

Top module: `aon_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, every register reads zero and both outputs are low. Reset leaves the NMI trigger set to level low.
- R2: Byte offsets are 0x00 vector (read only), 0x04 base (32 bits, read/write), 0x0C NMI control (bits 1:0, read/write), 0x40 enable (bits 15:0), 0x50 mask (bits 15:0). Unimplemented bits and unmapped offsets read as zero.
- R3: Writing to the pending register at 0x10 clears each bit written as 1 at the next clock edge and leaves bits written as 0 unchanged. A source hit in the same cycle wins over the clear.
- R4: NMI control value 0 selects level low and value 2 selects level high. In a level mode, NMI pending re-asserts after a clear for as long as the pin stays at the active level.
- R5: NMI control value 1 selects falling edge and value 3 selects rising edge. In an edge mode, NMI pending sets once per edge and stays clear after a clear while the pin holds its level.
- R6: A change on the NMI pin shows in pending bit 0 on the third rising clock edge after it, and not on the second.
- R7: A high level on source i (1 to 15) sets pending bit i at the next clock edge.
- R8: The coprocessor request output is high exactly when some pending bit has its enable bit 1 and its mask bit 0.
- R9: The dedicated NMI output equals pending bit 0 gated by enable bit 0 and mask bit 0. The bits of the other sources have no effect on it.
- R10: The vector register reads base + 4*k, where k is the lowest-numbered gated pending source. It reads the base alone when no source is gated.
- R11: Pending bits latch whatever the enable and mask bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Asynchronous NMI source (source 0) |
| ext_irq | input | 15 | Active-high level sources 1 to 15 |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| nmi_out | output | 1 | Gated source 0, to the main interrupt controller |
| cpu_irq_out | output | 1 | OR of all gated pending bits, to the coprocessor |

## Verification
The hardest case to reach is clearing the NMI bit while the pin is still at its active level. In a level mode the bit must come straight back. In an edge mode it must stay clear. The bench walks all four trigger codes. For each one it parks the pin at the inactive level, clears any stale pending state, makes the transition, and samples pending bit 0 after the second and the third clock edge. It then issues the clear with the pin held, and samples once more after the clear has taken effect.

// File: rtl/aon_irq_pkg.sv
package aon_irq_pkg;
    localparam int NUM_SRC = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_VECTOR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_BASE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_NMICFG = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h50;

    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'd0,
        TRIG_FALL   = 2'd1,
        TRIG_LVL_HI = 2'd2,
        TRIG_RISE   = 2'd3
    } trig_e;

    typedef struct packed {
        logic              wr_en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_wr_t;

    function automatic logic trig_hit(trig_e mode, logic cur, logic prev);
        case (mode)
            TRIG_LVL_LO: trig_hit = ~cur;
            TRIG_FALL:   trig_hit = prev & ~cur;
            TRIG_LVL_HI: trig_hit = cur;
            default:     trig_hit = cur & ~prev;
        endcase
    endfunction

    function automatic logic is_edge(trig_e mode);
        is_edge = mode[0];
    endfunction
endpackage

// File: rtl/nmi_front.sv
module nmi_front
    import aon_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    input  trig_e mode,
    output logic  hit
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN_W-2:0], pin};
    end

    assign hit = trig_hit(mode, chain_q[SYNC_STAGES-1], chain_q[SYNC_STAGES]);

    // R5
    edge_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (is_edge(mode) && hit) |=> !(is_edge(mode) && hit));
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    assign pend = pend_q;

    // R7
    set_latches_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));
    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_vec & ~set_vec) != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));
    // R3
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec == '0 && clr_vec == '0) |=> $stable(pend));
endmodule

// File: rtl/vec_encoder.sv
module vec_encoder #(
    parameter int N      = 16,
    parameter int DATA_W = 32
) (
    input  logic [N-1:0]      active,
    input  logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] vector,
    output logic              any
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (active[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    assign vector = base + DATA_W'({idx, 2'b00});
endmodule

// File: rtl/aon_irq_ctrl.sv
module aon_irq_ctrl
    import aon_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_pin,
    input  logic [N_SRC-1:1]  ext_irq,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              nmi_out,
    output logic              cpu_irq_out
);
    localparam int PAD_W = DW - N_SRC;

    bus_wr_t          req;
    logic [DW-1:0]    base_q;
    trig_e            mode_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] clr_vec;
    logic [N_SRC-1:0] gated;
    logic [DW-1:0]    vector;
    logic             any_gated;
    logic             nmi_hit;

    assign req.wr_en = bus_sel & bus_wr;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            mode_q <= TRIG_LVL_LO;
            en_q   <= '0;
            mask_q <= '0;
        end else if (req.wr_en) begin
            case (req.addr)
                OFS_BASE:   base_q <= req.wdata;
                OFS_NMICFG: mode_q <= trig_e'(req.wdata[1:0]);
                OFS_ENABLE: en_q   <= req.wdata[N_SRC-1:0];
                OFS_MASK:   mask_q <= req.wdata[N_SRC-1:0];
                default: ;
            endcase
        end
    end

    nmi_front #(.SYNC_STAGES(2)) u_nmi_front (
        .clk  (clk),
        .rst  (rst),
        .pin  (nmi_pin),
        .mode (mode_q),
        .hit  (nmi_hit)
    );

    assign set_vec = {ext_irq, nmi_hit};
    assign clr_vec = (req.wr_en && req.addr == OFS_PEND) ? req.wdata[N_SRC-1:0] : '0;

    pend_bank #(.N(N_SRC)) u_pend_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    assign gated = pend & en_q & ~mask_q;

    vec_encoder #(.N(N_SRC), .DATA_W(DW)) u_vec_encoder (
        .active (gated),
        .base   (base_q),
        .vector (vector),
        .any    (any_gated)
    );

    assign nmi_out     = gated[0];
    assign cpu_irq_out = any_gated;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_VECTOR: bus_rdata = vector;
                OFS_BASE:   bus_rdata = base_q;
                OFS_NMICFG: bus_rdata = {{(DW-2){1'b0}}, mode_q};
                OFS_PEND:   bus_rdata = {{PAD_W{1'b0}}, pend};
                OFS_ENABLE: bus_rdata = {{PAD_W{1'b0}}, en_q};
                OFS_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R9
    nmi_implies_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_out |-> cpu_irq_out);
    // R10
    idle_vector_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_irq_out |-> (vector == base_q));
    // R2
    enable_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr_en && req.addr == OFS_ENABLE) |=> (en_q == $past(req.wdata[N_SRC-1:0])));
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (pend == '0 && !nmi_out && !cpu_irq_out));
endmodule

// File: tb/test_aon_irq_ctrl.sv
module test_aon_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_pin = 1'b0;
    logic [15:1] ext_irq = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nmi_out;
    logic        cpu_irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [31:0] rv;
    localparam logic [31:0] BASE = 32'h0000_4A00;

    always #4 clk = ~clk;

    aon_irq_ctrl i_aon_irq_ctrl (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .ext_irq(ext_irq),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nmi_out(nmi_out), .cpu_irq_out(cpu_irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        edges(3);
        // R1: reset state while reset is still high
        rd(8'h00, rv); check("R1 vector", rv, 0);
        rd(8'h04, rv); check("R1 base", rv, 0);
        rd(8'h0C, rv); check("R1 nmicfg", rv, 0);
        rd(8'h10, rv); check("R1 pend", rv, 0);
        rd(8'h40, rv); check("R1 enable", rv, 0);
        rd(8'h50, rv); check("R1 mask", rv, 0);
        check("R1 outputs", {30'd0, nmi_out, cpu_irq_out}, 0);
        @(negedge clk); rst = 1'b0;

        // park NMI level high with pin low, then flush pending
        wr(8'h0C, 32'd2);
        edges(4);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, rv); check("R3 flush", rv, 0);

        // R2: widths and unmapped reads
        wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, rv); check("R2 enable width", rv, 32'h0000_FFFF);
        wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, rv); check("R2 mask width", rv, 32'h0000_FFFF);
        wr(8'h0C, 32'hFFFF_FFFE); rd(8'h0C, rv); check("R2 nmicfg width", rv, 32'd2);
        wr(8'h04, 32'h1234_5678); rd(8'h04, rv); check("R2 base", rv, 32'h1234_5678);
        rd(8'h20, rv); check("R2 unmapped", rv, 0);
        wr(8'h00, 32'hDEAD_BEEF); rd(8'h04, rv); check("R2 vector read only", rv, 32'h1234_5678);
        wr(8'h04, BASE);
        wr(8'h40, 0); wr(8'h50, 0);

        // R7 R8 R10 R11 R3 R9: sweep sources 1..15
        for (int i = 1; i < 16; i++) begin
            @(negedge clk); ext_irq = '0; ext_irq[i] = 1'b1;
            @(negedge clk); ext_irq = '0;
            rd(8'h10, rv); check("R7 pend set", rv, 32'd1 << i);
            check("R11 disabled latches, no request", {31'd0, cpu_irq_out}, 0);
            rd(8'h00, rv); check("R10 vector idle", rv, BASE);
            wr(8'h40, 32'd1 << i);
            check("R8 request enabled", {31'd0, cpu_irq_out}, 1);
            check("R9 other source no nmi", {31'd0, nmi_out}, 0);
            rd(8'h00, rv); check("R10 vector", rv, BASE + 32'(4 * i));
            wr(8'h50, 32'd1 << i);
            check("R8 request masked", {31'd0, cpu_irq_out}, 0);
            wr(8'h10, 32'd0);
            rd(8'h10, rv); check("R3 write zero no effect", rv, 32'd1 << i);
            wr(8'h10, 32'd1 << i);
            rd(8'h10, rv); check("R3 clear", rv, 0);
            wr(8'h40, 0); wr(8'h50, 0);
        end

        // R10: lowest-numbered gated source wins
        @(negedge clk); ext_irq = '0; ext_irq[3] = 1'b1; ext_irq[9] = 1'b1;
        @(negedge clk); ext_irq = '0;
        wr(8'h40, 32'hFFFF);
        rd(8'h00, rv); check("R10 lowest", rv, BASE + 32'd12);
        wr(8'h50, 32'h0008);
        rd(8'h00, rv); check("R10 next after mask", rv, BASE + 32'd36);
        wr(8'h10, 32'hFFFF); wr(8'h50, 0); wr(8'h40, 0);

        // R4 R5 R6 R9: all four NMI trigger codes
        for (int m = 0; m < 4; m++) begin
            logic inact;
            inact = (m == 0 || m == 1);
            @(negedge clk); nmi_pin = inact;
            edges(4);
            wr(8'h0C, 32'(m));
            edges(4);
            wr(8'h10, 32'h1);
            wr(8'h40, 32'h1);
            rd(8'h10, rv); check("R6 idle before change", rv, 0);
            nmi_pin = ~inact;
            edges(2);
            rd(8'h10, rv); check("R6 not yet at edge two", rv, 0);
            edges(1);
            rd(8'h10, rv); check("R6 set at edge three", rv, 1);
            check("R9 nmi out", {31'd0, nmi_out}, 1);
            wr(8'h50, 32'h1);
            check("R9 nmi masked", {31'd0, nmi_out}, 0);
            wr(8'h50, 0);
            wr(8'h10, 32'h1);
            edges(2);
            rd(8'h10, rv);
            if (m[0]) check("R5 edge stays clear", rv, 0);
            else      check("R4 level re-asserts", rv, 1);
            @(negedge clk); nmi_pin = inact;
            edges(4);
            wr(8'h10, 32'h1);
            rd(8'h10, rv); check("R4 R5 clear at inactive", rv, 0);
            wr(8'h40, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule